// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block produces the interrupt flags for a bank of message buffers in a bus controller. Buffer 0 is a transmit queue. Buffers 1 and up are FIFOs, and each one can be set up as a receive FIFO or a transmit FIFO. For each buffer the block takes the current occupancy count and depth. From these it derives level-type status flags. Software cannot clear these flags; each one follows its occupancy condition and drops as soon as the condition ends.

Each buffer also has two sticky event flags, set by event pulses and cleared by software. The overrun flag is set when a message arrives at a full receive FIFO. The attempts-exhausted flag is set when a transmit buffer gives up retransmitting.

Each buffer has its own enable mask. The enabled status sources of a buffer are ORed into one bit. That bit goes to either a 32-bit receive vector or a 32-bit transmit vector, depending on the buffer's direction. The transmit queue always owns bit 0 of the transmit vector.

Top module: `fifo_irq_agg`

## Requirements
- R1: After reset the enable masks, overrun flags and attempts-exhausted flags are all 0, and both interrupt vectors read 0.
- R2: For a receive FIFO with count c and depth d, status bit 0 is "not empty" (c != 0), bit 1 is "half full" (2c >= d) and bit 2 is "full" (c >= d). These bits appear on `stat_flags[3b+:3]` one clock after the inputs.
- R3: For a transmit FIFO, status bit 0 is "not full" (c < d), bit 1 is "half empty" (2c <= d) and bit 2 is "empty" (c == 0). These bits also appear one clock after the inputs.
- R4: Buffer 0 is treated as a transmit buffer whatever `fifo_is_tx[0]` says. Its status bit 1 always reads 0, and enable bit 1 written for buffer 0 has no effect.
- R5: Status flags have no software clear. The clear pulses leave them unchanged, and each flag drops one clock after its condition stops holding.
- R6: A pulse on `en_we[b]` loads `en_wdata[3b+:3]` into the mask of buffer b. Mask bit k enables status bit k.
- R7: A buffer's interrupt is the OR of its status bits ANDed with its mask. For b >= 1, a receive buffer drives `rx_irq_vec[b]` and a transmit buffer drives `tx_irq_vec[b]`, and the other vector's bit reads 0. Buffer 0 drives `tx_irq_vec[0]`, and `rx_irq_vec[0]` is always 0. The sticky flags do not feed the vectors.
- R8: `msg_rcvd[b]` on a receive FIFO (b >= 1) whose count is at least its depth in that same cycle sets `ovf_flags[b]` on the next clock. The pulse has no effect on a FIFO that is not full or is set to transmit.
- R9: `retry_exhaust[b]` on a transmit buffer (buffer 0, or `fifo_is_tx[b]` = 1) sets `att_flags[b]` on the next clock. The pulse has no effect on a receive FIFO.
- R10: `ovf_clr[b]` and `att_clr[b]` clear their flag on the next clock. If a set and a clear arrive in the same cycle, the flag ends up set. With neither a set nor a clear, a flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_cnt | input | NUM_BUF*CNT_W | Occupancy count per buffer |
| fifo_depth | input | NUM_BUF*CNT_W | Depth per buffer |
| fifo_is_tx | input | NUM_BUF | Direction per buffer, 1 = transmit (bit 0 ignored) |
| en_we | input | NUM_BUF | Mask write strobe per buffer |
| en_wdata | input | NUM_BUF*3 | Mask write data, 3 bits per buffer |
| msg_rcvd | input | NUM_BUF | Message-received pulse per buffer |
| retry_exhaust | input | NUM_BUF | Retransmission-exhausted pulse per buffer |
| ovf_clr | input | NUM_BUF | Overrun flag clear pulse per buffer |
| att_clr | input | NUM_BUF | Attempts-exhausted flag clear pulse per buffer |
| stat_flags | output | NUM_BUF*3 | Registered status bits, 3 per buffer |
| ovf_flags | output | NUM_BUF | Sticky overrun flags |
| att_flags | output | NUM_BUF | Sticky attempts-exhausted flags |
| rx_irq_vec | output | NUM_BUF | Receive interrupt vector |
| tx_irq_vec | output | NUM_BUF | Transmit interrupt vector |

## Verification
Every output is due exactly one clock after the stimulus that causes it. This covers count and direction changes, which reach the status bits and the vectors. It covers mask writes, which reach the vectors, and event and clear pulses, which reach the sticky flags. The driver applies each stimulus on a falling edge and computes the state expected after the next rising edge. It queues that expected state as one item. The monitor samples 2 ns after each rising edge, so it compares every item exactly one register stage after its stimulus and never during an edge.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned SRC_N = 3;
  typedef logic [SRC_N-1:0] src_t;
  // transmit queue has no half source
  localparam src_t TXQ_MASK = 3'b101;
  localparam src_t ALL_MASK = 3'b111;

  function automatic logic is_full(input logic [31:0] cnt, input logic [31:0] depth);
    return cnt >= depth;
  endfunction

  // bit0 not empty, bit1 half full, bit2 full
  function automatic src_t rx_status(input logic [31:0] cnt, input logic [31:0] depth);
    src_t s;
    s[0] = (cnt != 32'd0);
    s[1] = ((cnt << 1) >= depth);
    s[2] = is_full(cnt, depth);
    return s;
  endfunction

  // bit0 not full, bit1 half empty, bit2 empty
  function automatic src_t tx_status(input logic [31:0] cnt, input logic [31:0] depth);
    src_t s;
    s[0] = (cnt < depth);
    s[1] = ((cnt << 1) <= depth);
    s[2] = (cnt == 32'd0);
    return s;
  endfunction
endpackage

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter bit          IS_TXQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] depth,
  input  logic             dir_tx,
  output src_t             stat_q,
  output logic             tx_q,
  output logic             tx_now,
  output logic             full_now
);
  localparam int unsigned PAD_W = 32 - CNT_W;
  localparam src_t        MASK  = IS_TXQ ? TXQ_MASK : ALL_MASK;

  logic [31:0] cnt_w;
  logic [31:0] dep_w;
  src_t        stat_d;

  assign cnt_w    = {{PAD_W{1'b0}}, cnt};
  assign dep_w    = {{PAD_W{1'b0}}, depth};
  assign tx_now   = IS_TXQ ? 1'b1 : dir_tx;
  assign full_now = is_full(cnt_w, dep_w);

  always_comb begin
    if (tx_now) stat_d = tx_status(cnt_w, dep_w);
    else        stat_d = rx_status(cnt_w, dep_w);
    stat_d = stat_d & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      tx_q   <= IS_TXQ;
    end else begin
      stat_q <= stat_d;
      tx_q   <= tx_now;
    end
  end
endmodule

// File: rtl/fifo_irq_enables.sv
module fifo_irq_enables
  import fifo_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_BUF-1:0]       we,
  input  logic [NUM_BUF*SRC_N-1:0] wdata,
  output logic [NUM_BUF*SRC_N-1:0] en_q
);
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_en
    localparam src_t MASK = (b == 0) ? TXQ_MASK : ALL_MASK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q[b*SRC_N +: SRC_N] <= '0;
      else if (we[b]) en_q[b*SRC_N +: SRC_N] <= wdata[b*SRC_N +: SRC_N] & MASK;
    end
  end
endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky #(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] set,
  input  logic [NUM_BUF-1:0] clr,
  output logic [NUM_BUF-1:0] flag_q
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | set;
  end
endmodule

// File: rtl/fifo_irq_combine.sv
module fifo_irq_combine
  import fifo_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic [NUM_BUF*SRC_N-1:0] stat,
  input  logic [NUM_BUF*SRC_N-1:0] en,
  input  logic [NUM_BUF-1:0]       tx_sel,
  output logic [NUM_BUF-1:0]       buf_irq,
  output logic [NUM_BUF-1:0]       rx_vec,
  output logic [NUM_BUF-1:0]       tx_vec
);
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_cmb
    assign buf_irq[b] = |(stat[b*SRC_N +: SRC_N] & en[b*SRC_N +: SRC_N]);
    if (b == 0) begin : g_txq
      assign tx_vec[b] = buf_irq[b];
      assign rx_vec[b] = 1'b0;
    end else begin : g_fifo
      assign tx_vec[b] = buf_irq[b] &  tx_sel[b];
      assign rx_vec[b] = buf_irq[b] & ~tx_sel[b];
    end
  end
endmodule

// File: rtl/fifo_irq_agg.sv
module fifo_irq_agg
  import fifo_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  parameter int unsigned CNT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_BUF*CNT_W-1:0] occ_cnt,
  input  logic [NUM_BUF*CNT_W-1:0] fifo_depth,
  input  logic [NUM_BUF-1:0]       fifo_is_tx,
  input  logic [NUM_BUF-1:0]       en_we,
  input  logic [NUM_BUF*3-1:0]     en_wdata,
  input  logic [NUM_BUF-1:0]       msg_rcvd,
  input  logic [NUM_BUF-1:0]       retry_exhaust,
  input  logic [NUM_BUF-1:0]       ovf_clr,
  input  logic [NUM_BUF-1:0]       att_clr,
  output logic [NUM_BUF*3-1:0]     stat_flags,
  output logic [NUM_BUF-1:0]       ovf_flags,
  output logic [NUM_BUF-1:0]       att_flags,
  output logic [NUM_BUF-1:0]       rx_irq_vec,
  output logic [NUM_BUF-1:0]       tx_irq_vec
);
  logic [NUM_BUF-1:0]       tx_q;
  logic [NUM_BUF-1:0]       tx_now;
  logic [NUM_BUF-1:0]       full_now;
  logic [NUM_BUF-1:0]       ovf_set;
  logic [NUM_BUF-1:0]       att_set;
  logic [NUM_BUF-1:0]       buf_irq;
  logic [NUM_BUF*SRC_N-1:0] en_q;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    fifo_irq_status #(.CNT_W(CNT_W), .IS_TXQ(b == 0)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (occ_cnt[b*CNT_W +: CNT_W]),
      .depth    (fifo_depth[b*CNT_W +: CNT_W]),
      .dir_tx   (fifo_is_tx[b]),
      .stat_q   (stat_flags[b*SRC_N +: SRC_N]),
      .tx_q     (tx_q[b]),
      .tx_now   (tx_now[b]),
      .full_now (full_now[b])
    );
  end

  assign ovf_set = msg_rcvd & ~tx_now & full_now;
  assign att_set = retry_exhaust & tx_now;

  fifo_irq_enables #(.NUM_BUF(NUM_BUF)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (en_we),
    .wdata (en_wdata),
    .en_q  (en_q)
  );

  fifo_irq_sticky #(.NUM_BUF(NUM_BUF)) u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ovf_set),
    .clr    (ovf_clr),
    .flag_q (ovf_flags)
  );

  fifo_irq_sticky #(.NUM_BUF(NUM_BUF)) u_att (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (att_set),
    .clr    (att_clr),
    .flag_q (att_flags)
  );

  fifo_irq_combine #(.NUM_BUF(NUM_BUF)) u_cmb (
    .stat    (stat_flags),
    .en      (en_q),
    .tx_sel  (tx_q),
    .buf_irq (buf_irq),
    .rx_vec  (rx_irq_vec),
    .tx_vec  (tx_irq_vec)
  );
endmodule

// File: rtl/fifo_irq_agg_chk.sv
module fifo_irq_agg_chk #(
  parameter int unsigned NUM_BUF = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               txq_half,
  input logic [NUM_BUF-1:0] rx_irq_vec,
  input logic [NUM_BUF-1:0] tx_irq_vec,
  input logic [NUM_BUF-1:0] buf_irq,
  input logic [NUM_BUF-1:0] tx_now,
  input logic [NUM_BUF-1:0] ovf_set,
  input logic [NUM_BUF-1:0] att_set,
  input logic [NUM_BUF-1:0] ovf_clr,
  input logic [NUM_BUF-1:0] att_clr,
  input logic [NUM_BUF-1:0] ovf_flags,
  input logic [NUM_BUF-1:0] att_flags
);
  AST_RX_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rx_irq_vec[0] == 1'b0); // R7
  AST_VEC_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) (rx_irq_vec & tx_irq_vec) == '0); // R7
  AST_VEC_COVERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (rx_irq_vec | tx_irq_vec) == buf_irq); // R7
  AST_TXQ_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n) txq_half == 1'b0); // R4
  AST_OVF_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n) (ovf_set & tx_now) == '0); // R8
  AST_ATT_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n) (att_set & ~tx_now) == '0); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (ovf_set != '0) |=> ((ovf_flags & $past(ovf_set)) == $past(ovf_set))); // R8
  AST_ATT_SET: assert property (@(posedge clk) disable iff (!rst_n) (att_set != '0) |=> ((att_flags & $past(att_set)) == $past(att_set))); // R9
  AST_OVF_CLR: assert property (@(posedge clk) disable iff (!rst_n) (ovf_clr != '0) |=> ((ovf_flags & $past(ovf_clr & ~ovf_set)) == '0)); // R10
  AST_ATT_CLR: assert property (@(posedge clk) disable iff (!rst_n) (att_clr != '0) |=> ((att_flags & $past(att_clr & ~att_set)) == '0)); // R10
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flags != '0) |=> ((ovf_flags & $past(ovf_flags & ~ovf_clr)) == $past(ovf_flags & ~ovf_clr))); // R10
endmodule

bind fifo_irq_agg fifo_irq_agg_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txq_half   (stat_flags[1]),
  .rx_irq_vec (rx_irq_vec),
  .tx_irq_vec (tx_irq_vec),
  .buf_irq    (buf_irq),
  .tx_now     (tx_now),
  .ovf_set    (ovf_set),
  .att_set    (att_set),
  .ovf_clr    (ovf_clr),
  .att_clr    (att_clr),
  .ovf_flags  (ovf_flags),
  .att_flags  (att_flags)
);

// File: tb/fifo_irq_agg_tb.sv
`timescale 1ns/1ps
module fifo_irq_agg_tb;
  localparam int NB = 32;
  localparam int CW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*CW-1:0] occ_cnt = '0, fifo_depth = '0;
  logic [NB-1:0]   fifo_is_tx = '0, en_we = '0, msg_rcvd = '0, retry_exhaust = '0;
  logic [NB-1:0]   ovf_clr = '0, att_clr = '0;
  logic [NB*3-1:0] en_wdata = '0;
  logic [NB*3-1:0] stat_flags;
  logic [NB-1:0]   ovf_flags, att_flags, rx_irq_vec, tx_irq_vec;

  always #10 clk = ~clk;

  fifo_irq_agg #(.NUM_BUF(NB), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .occ_cnt(occ_cnt), .fifo_depth(fifo_depth),
    .fifo_is_tx(fifo_is_tx), .en_we(en_we), .en_wdata(en_wdata),
    .msg_rcvd(msg_rcvd), .retry_exhaust(retry_exhaust), .ovf_clr(ovf_clr),
    .att_clr(att_clr), .stat_flags(stat_flags), .ovf_flags(ovf_flags),
    .att_flags(att_flags), .rx_irq_vec(rx_irq_vec), .tx_irq_vec(tx_irq_vec)
  );

  typedef struct {
    logic [NB-1:0]   rx, tx, ovf, att;
    logic [NB*3-1:0] st;
    string           req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int       cnt_m[NB], dep_m[NB];
  bit       dir_m[NB];
  bit [2:0] en_m[NB], wdat_p[NB];
  bit       ovf_m[NB], att_m[NB];
  bit       we_p[NB], rcv_p[NB], rex_p[NB], oc_p[NB], ac_p[NB];

  function automatic bit [2:0] model_stat(int b);
    bit [2:0] r;
    int c = cnt_m[b];
    int d = dep_m[b];
    if (b == 0 || dir_m[b]) begin
      r = {c == 0, 2*c <= d, c < d};
      if (b == 0) r[1] = 1'b0;
    end else begin
      r = {c >= d, 2*c >= d, c > 0};
    end
    return r;
  endfunction

  task automatic cmp(string req, string what, logic [NB*3-1:0] act, logic [NB*3-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    exp_t e;
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      occ_cnt[b*CW +: CW]    = CW'(cnt_m[b]);
      fifo_depth[b*CW +: CW] = CW'(dep_m[b]);
      fifo_is_tx[b]    = dir_m[b];
      en_we[b]         = we_p[b];
      en_wdata[b*3 +: 3] = wdat_p[b];
      msg_rcvd[b]      = rcv_p[b];
      retry_exhaust[b] = rex_p[b];
      ovf_clr[b]       = oc_p[b];
      att_clr[b]       = ac_p[b];
    end
    e.req = req;
    for (int b = 0; b < NB; b++) begin
      bit tx = (b == 0) || dir_m[b];
      bit irq;
      bit [2:0] s = model_stat(b);
      if (we_p[b]) en_m[b] = wdat_p[b] & ((b == 0) ? 3'b101 : 3'b111);
      ovf_m[b] = (rcv_p[b] && !tx && cnt_m[b] >= dep_m[b]) || (ovf_m[b] && !oc_p[b]);
      att_m[b] = (rex_p[b] && tx) || (att_m[b] && !ac_p[b]);
      irq = |(s & en_m[b]);
      e.st[b*3 +: 3] = s;
      e.rx[b]  = irq && !tx;
      e.tx[b]  = irq && tx;
      e.ovf[b] = ovf_m[b];
      e.att[b] = att_m[b];
      we_p[b] = 0; rcv_p[b] = 0; rex_p[b] = 0; oc_p[b] = 0; ac_p[b] = 0;
    end
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.req, "stat_flags", stat_flags, e.st);
        cmp(e.req, "rx_irq_vec", {64'd0, rx_irq_vec}, {64'd0, e.rx});
        cmp(e.req, "tx_irq_vec", {64'd0, tx_irq_vec}, {64'd0, e.tx});
        cmp(e.req, "ovf_flags",  {64'd0, ovf_flags},  {64'd0, e.ovf});
        cmp(e.req, "att_flags",  {64'd0, att_flags},  {64'd0, e.att});
      end
    end
  end

  initial begin : watchdog
    #(20ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int lv[5] = '{8, 16, 0, 7, 9};
    for (int b = 0; b < NB; b++) begin
      cnt_m[b] = 0; dep_m[b] = 16; dir_m[b] = (b >= 16);
      en_m[b] = 0; ovf_m[b] = 0; att_m[b] = 0; wdat_p[b] = 0;
      we_p[b] = 0; rcv_p[b] = 0; rex_p[b] = 0; oc_p[b] = 0; ac_p[b] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    cmp("R1", "rx_irq_vec", {64'd0, rx_irq_vec}, '0);
    cmp("R1", "tx_irq_vec", {64'd0, tx_irq_vec}, '0);
    cmp("R1", "ovf_flags",  {64'd0, ovf_flags},  '0);
    cmp("R1", "att_flags",  {64'd0, att_flags},  '0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    // R2/R3 mixed counts, masks still zero
    for (int b = 0; b < NB; b++) cnt_m[b] = (b * 3) % 17;
    step("R2");
    step("R3");
    // R6 write all masks
    for (int b = 0; b < NB; b++) begin we_p[b] = 1; wdat_p[b] = 3'b111; end
    step("R6");
    step("R7");
    foreach (lv[i]) begin
      for (int b = 0; b < NB; b++) cnt_m[b] = lv[i];
      step((i % 2 == 0) ? "R2" : "R3");
    end
    // R4: only half source enabled, TXQ at quarter
    for (int b = 0; b < NB; b++) begin we_p[b] = 1; wdat_p[b] = 3'b010; cnt_m[b] = 4; end
    step("R4");
    step("R4");
    // R7: direction flip moves the bit
    dir_m[5] = 1; dir_m[20] = 0;
    step("R7");
    for (int b = 0; b < NB; b++) begin we_p[b] = 1; wdat_p[b] = 3'b100; end
    step("R7");
    dir_m[5] = 0; dir_m[20] = 1; dir_m[0] = 1;
    step("R4");
    // R8 overrun
    for (int b = 0; b < NB; b++) cnt_m[b] = 16;
    cnt_m[4] = 5;
    step("R8");
    rcv_p[3] = 1; rcv_p[4] = 1; rcv_p[20] = 1; rcv_p[0] = 1;
    step("R8");
    step("R8");
    // R9 attempts exhausted
    rex_p[0] = 1; rex_p[20] = 1; rex_p[3] = 1;
    step("R9");
    step("R9");
    // R10 clears, set beats clear, R5 clears leave status alone
    oc_p[3] = 1;
    step("R10");
    ac_p[0] = 1; rex_p[0] = 1; ac_p[20] = 1;
    step("R10");
    step("R10");
    rcv_p[7] = 1; oc_p[7] = 1;
    step("R10");
    for (int b = 0; b < NB; b++) begin oc_p[b] = 1; ac_p[b] = 1; end
    step("R5");
    for (int b = 0; b < NB; b++) cnt_m[b] = 2;
    step("R5");
    step("R5");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule